// File: doc/BRIEF.md
# Partitioned 8x16 Rounding Multiplier

This block is a SIMD multiplier for pixel arithmetic. Each lane multiplies an unsigned 8-bit pixel component by a signed 16-bit coefficient. It keeps the middle sixteen bits of the product and rounds half up. All lanes work in parallel, and the results are packed into a 64-bit word. A 9-bit operation code picks one of seven variants. The variants fall into four groups:

- Plain four-lane multiply.
- Broadcast of a single coefficient taken from the upper or lower half of a word.
- Selection of the high or low byte of each 16-bit lane as the pixel factor.
- A two-lane form that places each result inside a 32-bit lane, shifted left by seven.

Operands and the operation code arrive with a valid flag. The result appears with a matching valid flag exactly two clock cycles later. A new operation may be issued on every cycle. Register storage and instruction decode are outside the block.

Top module: `pmul8x16_unit`

## Requirements
- R1: The lane function takes an unsigned 8-bit factor f and a signed 16-bit coefficient c and forms p = f*c in two's complement. It returns p[23:8] + p[7] modulo 2^16. For example, f=0x01 with c=0xFFFF gives 0x0000, f=0x80 with c=0x0001 gives 0x0001, and f=0xFF with c=0x8000 gives 0x8080.
- R2: Operation code 0x031 is the basic form. Result bits [16i+15:16i] equal the lane function of opa[8i+7:8i] and opb[16i+15:16i], for i = 0..3. opa[63:32] is ignored.
- R3: Operation code 0x033 broadcasts opb[31:16] as the coefficient of all four lanes. The factor of lane i is opa[8i+7:8i].
- R4: Operation code 0x035 broadcasts opb[15:0] as the coefficient of all four lanes. The factor of lane i is opa[8i+7:8i].
- R5: Operation codes 0x036 and 0x037 are the selective forms. Lane i multiplies a byte of opa lane i by opb[16i+15:16i]. Code 0x036 takes byte opa[16i+15:16i+8], and code 0x037 takes byte opa[16i+7:16i]. Lane i goes to result bits [16i+15:16i].
- R6: Operation codes 0x038 and 0x039 are the double forms. For lanes i = 0 and 1, they take the factor from opa[16i+15:16i+8] (0x038) or from opa[16i+7:16i] (0x039), with coefficient opb[16i+15:16i]. The 16-bit result goes to result bits [32i+22:32i+7]. Every other result bit is zero.
- R7: Any other operation code yields a result of all zeros.
- R8: out_valid equals in_valid from two cycles earlier, and a new operation is accepted every cycle. While out_valid is low, result keeps its last value.
- R9: After reset, out_valid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present on the inputs |
| op_code | input | 9 | Variant select |
| opa | input | 64 | Pixel factor operand |
| opb | input | 64 | Coefficient operand |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| result | output | 64 | Packed rounded products |

## Verification
The bench drives products whose rounding bit carries through sixteen ones, so a lane that drops the wrap or rounds on the wrong bit reports 0x10000-style residues or off-by-one values. It also sends a full-scale negative coefficient against 0xFF, which exposes sign extension done on the factor instead of the coefficient. Broadcast and selective codes use operands whose upper and lower halves differ, so a swapped half or byte shows up at once. A double form that places its result at the wrong bit offset, or leaves bits set outside its windows, fails the exact 64-bit comparison. Unknown codes, valid bubbles and back-to-back issue test the zero result, the held output and the two-cycle latency.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int OPW = 9;

  localparam logic [OPW-1:0] OP_BASIC  = 9'h031;
  localparam logic [OPW-1:0] OP_ALPHA_H = 9'h033;
  localparam logic [OPW-1:0] OP_ALPHA_L = 9'h035;
  localparam logic [OPW-1:0] OP_SEL_H  = 9'h036;
  localparam logic [OPW-1:0] OP_SEL_L  = 9'h037;
  localparam logic [OPW-1:0] OP_DBL_H  = 9'h038;
  localparam logic [OPW-1:0] OP_DBL_L  = 9'h039;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_QUAD = 2'd1,
    PM_DBL  = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pmul_route.sv
module pmul_route
  import pmul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int FW    = 8,
  parameter int CW    = 16,
  parameter int DW    = 64
) (
  input  logic [OPW-1:0]            op,
  input  logic [DW-1:0]             a,
  input  logic [DW-1:0]             b,
  output pm_mode_e                  mode,
  output logic [LANES-1:0][FW-1:0]  fac,
  output logic [LANES-1:0][CW-1:0]  coef
);
  localparam int HALF = DW / 2;

  logic [CW-1:0] bcast_hi;
  logic [CW-1:0] bcast_lo;

  assign bcast_hi = b[HALF-1 -: CW];
  assign bcast_lo = b[CW-1:0];

  always_comb begin
    case (op)
      OP_BASIC, OP_ALPHA_H, OP_ALPHA_L, OP_SEL_H, OP_SEL_L: mode = PM_QUAD;
      OP_DBL_H, OP_DBL_L:                                  mode = PM_DBL;
      default:                                             mode = PM_NONE;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IN_DBL = (i < LANES / 2);
    always_comb begin
      fac[i]  = '0;
      coef[i] = '0;
      case (op)
        OP_BASIC: begin
          fac[i]  = a[FW*i +: FW];
          coef[i] = b[CW*i +: CW];
        end
        OP_ALPHA_H: begin
          fac[i]  = a[FW*i +: FW];
          coef[i] = bcast_hi;
        end
        OP_ALPHA_L: begin
          fac[i]  = a[FW*i +: FW];
          coef[i] = bcast_lo;
        end
        OP_SEL_H: begin
          fac[i]  = a[CW*i + FW +: FW];
          coef[i] = b[CW*i +: CW];
        end
        OP_SEL_L: begin
          fac[i]  = a[CW*i +: FW];
          coef[i] = b[CW*i +: CW];
        end
        OP_DBL_H: begin
          if (IN_DBL) begin
            fac[i]  = a[CW*i + FW +: FW];
            coef[i] = b[CW*i +: CW];
          end
        end
        OP_DBL_L: begin
          if (IN_DBL) begin
            fac[i]  = a[CW*i +: FW];
            coef[i] = b[CW*i +: CW];
          end
        end
        default: begin
          fac[i]  = '0;
          coef[i] = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int FW = 8,
  parameter int CW = 16
) (
  input  logic [FW-1:0] fac,
  input  logic [CW-1:0] coef,
  output logic [CW-1:0] res
);
  localparam int PW = FW + CW;

  logic signed [PW-1:0] prod;
  logic        [PW-1:0] rnd_sum;
  logic        [FW-1:0] unused_frac;

  // unsigned factor times signed coefficient fits PW signed bits
  assign prod = $signed({1'b0, fac}) * $signed(coef);

  // adding half an LSB of the kept field then truncating is round half up
  assign rnd_sum = prod + PW'(1 << (FW - 1));
  assign {res, unused_frac} = rnd_sum;
endmodule

// File: rtl/pmul_place.sv
module pmul_place
  import pmul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 16,
  parameter int DW    = 64,
  parameter int DSH   = 7
) (
  input  pm_mode_e                 mode,
  input  logic [LANES-1:0][CW-1:0] lane_res,
  output logic [DW-1:0]            packed_res
);
  localparam int DLANES = LANES / 2;
  localparam int DLW    = DW / DLANES;

  logic [DW-1:0] quad_word;
  logic [DW-1:0] dbl_word;

  for (genvar i = 0; i < LANES; i++) begin : g_quad
    assign quad_word[CW*i +: CW] = lane_res[i];
  end

  for (genvar j = 0; j < DLANES; j++) begin : g_dbl
    assign dbl_word[DLW*j +: DLW] = DLW'({lane_res[j], DSH'(0)});
  end

  always_comb begin
    case (mode)
      PM_QUAD: packed_res = quad_word;
      PM_DBL:  packed_res = dbl_word;
      default: packed_res = '0;
    endcase
  end
endmodule

// File: rtl/pmul8x16_unit.sv
module pmul8x16_unit
  import pmul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int FW    = 8,
  parameter int CW    = 16,
  parameter int DW    = 64,
  parameter int DSH   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [8:0]     op_code,
  input  logic [63:0]    opa,
  input  logic [63:0]    opb,
  output logic           out_valid,
  output logic [63:0]    result
);
  localparam int DLW = DW / (LANES / 2);
  localparam logic [DLW-1:0] DWIN = DLW'(((1 << CW) - 1) << DSH);
  localparam logic [DW-1:0]  DBL_MASK = {(LANES / 2){DWIN}};

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  // stage 0: routing
  pm_mode_e                 rt_mode;
  logic [LANES-1:0][FW-1:0] rt_fac;
  logic [LANES-1:0][CW-1:0] rt_coef;

  pmul_route #(.LANES(LANES), .FW(FW), .CW(CW), .DW(DW)) route_i (
    .op   (op_code),
    .a    (opa),
    .b    (opb),
    .mode (rt_mode),
    .fac  (rt_fac),
    .coef (rt_coef)
  );

  // stage 1 registers
  logic                     v_s1, v_s1_nxt;
  pm_mode_e                 mode_s1, mode_s1_nxt;
  logic [LANES-1:0][FW-1:0] fac_s1, fac_s1_nxt;
  logic [LANES-1:0][CW-1:0] coef_s1, coef_s1_nxt;
  logic                     ld_s1;

  assign ld_s1 = in_valid;

  always_comb begin
    v_s1_nxt    = in_valid;
    mode_s1_nxt = mode_s1;
    fac_s1_nxt  = fac_s1;
    coef_s1_nxt = coef_s1;
    if (ld_s1) begin
      mode_s1_nxt = rt_mode;
      fac_s1_nxt  = rt_fac;
      coef_s1_nxt = rt_coef;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      v_s1    <= 1'b0;
      mode_s1 <= PM_NONE;
      fac_s1  <= '0;
      coef_s1 <= '0;
    end else begin
      v_s1    <= v_s1_nxt;
      mode_s1 <= mode_s1_nxt;
      fac_s1  <= fac_s1_nxt;
      coef_s1 <= coef_s1_nxt;
    end
  end

  // stage 1 compute
  logic [LANES-1:0][CW-1:0] lane_res;
  logic [DW-1:0]            packed_res;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    pmul_lane #(.FW(FW), .CW(CW)) lane_i (
      .fac  (fac_s1[i]),
      .coef (coef_s1[i]),
      .res  (lane_res[i])
    );
  end

  pmul_place #(.LANES(LANES), .CW(CW), .DW(DW), .DSH(DSH)) place_i (
    .mode       (mode_s1),
    .lane_res   (lane_res),
    .packed_res (packed_res)
  );

  // stage 2 registers
  logic          v_s2_nxt;
  logic [DW-1:0] res_s2_nxt;

  always_comb begin
    v_s2_nxt   = v_s1;
    res_s2_nxt = result;
    if (v_s1) res_s2_nxt = packed_res;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= v_s2_nxt;
      result    <= res_s2_nxt;
    end
  end

  // R8: valid walks through both stages one cycle each
  p_valid_s1_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_valid |=> v_s1);
  p_bubble_s1_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_valid |=> !v_s1);
  p_valid_out_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    v_s1 |=> out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !v_s1 |=> $stable(result));
  // R6: double forms leave everything outside the two windows clear
  p_dbl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (v_s1 && mode_s1 == PM_DBL) |=> ((result & ~DBL_MASK) == '0));
  // R7: unknown codes give zero
  p_unknown_zero_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (v_s1 && mode_s1 == PM_NONE) |=> (result == '0));
endmodule

// File: tb/pmul8x16_unit_tb_top.sv
module pmul8x16_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [8:0]  op_code;
  logic [63:0] opa;
  logic [63:0] opb;
  logic        out_valid;
  logic [63:0] result;

  int total;
  int bad;

  pmul8x16_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] lref(logic [7:0] f, logic [15:0] c);
    int p;
    logic [31:0] pb;
    p  = int'(f) * int'($signed(c));
    pb = p;
    return pb[23:8] + {15'b0, pb[7]};
  endfunction

  function automatic logic [63:0] model(logic [8:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    r = '0;
    case (op)
      9'h031: for (int i = 0; i < 4; i++) r[16*i +: 16] = lref(a[8*i +: 8], b[16*i +: 16]);
      9'h033: for (int i = 0; i < 4; i++) r[16*i +: 16] = lref(a[8*i +: 8], b[31:16]);
      9'h035: for (int i = 0; i < 4; i++) r[16*i +: 16] = lref(a[8*i +: 8], b[15:0]);
      9'h036: for (int i = 0; i < 4; i++) r[16*i +: 16] = lref(a[16*i+8 +: 8], b[16*i +: 16]);
      9'h037: for (int i = 0; i < 4; i++) r[16*i +: 16] = lref(a[16*i +: 8], b[16*i +: 16]);
      9'h038: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = lref(a[16*i+8 +: 8], b[16*i +: 16]);
      9'h039: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = lref(a[16*i +: 8], b[16*i +: 16]);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [8:0] op);
    case (op)
      9'h031: return "R2";
      9'h033: return "R3";
      9'h035: return "R4";
      9'h036, 9'h037: return "R5";
      9'h038, 9'h039: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // two-deep history of issued operations
  logic        h_v [2];
  logic [63:0] h_e [2];
  string       h_t [2];
  logic [63:0] last_res;

  task automatic step(logic v, logic [8:0] op, logic [63:0] a, logic [63:0] b, string tg);
    @(negedge clk);
    chk("R8", {63'b0, out_valid}, {63'b0, h_v[1]});
    if (h_v[1]) begin
      chk(h_t[1], result, h_e[1]);
      last_res = h_e[1];
    end else begin
      chk("R8", result, last_res);
    end
    h_v[1] = h_v[0];
    h_e[1] = h_e[0];
    h_t[1] = h_t[0];
    in_valid = v;
    op_code  = op;
    opa      = a;
    opb      = b;
    h_v[0]   = v;
    h_e[0]   = model(op, a, b);
    h_t[0]   = (tg == "") ? tag_of(op) : tg;
  endtask

  logic [8:0] ops [9];

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    total = 0;
    bad = 0;
    unused_seed = $urandom(32'h5EED1234);
    ops[0] = 9'h031; ops[1] = 9'h033; ops[2] = 9'h035;
    ops[3] = 9'h036; ops[4] = 9'h037; ops[5] = 9'h038;
    ops[6] = 9'h039; ops[7] = 9'h032; ops[8] = 9'h03A;
    rst_n = 1'b0;
    in_valid = 1'b0;
    op_code = '0;
    opa = '0;
    opb = '0;
    for (int k = 0; k < 2; k++) begin
      h_v[k] = 1'b0;
      h_e[k] = '0;
      h_t[k] = "R8";
    end
    last_res = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9", {63'b0, out_valid}, 64'd0);
    chk("R9", result, 64'd0);

    // R1 rounding corners in the basic form
    step(1'b1, 9'h031, 64'hDEAD_BEEF_FF7F_8001, 64'h8000_0001_0001_FFFF, "R1");
    chk("R1", model(9'h031, 64'hFF7F_8001, 64'h8000_0001_0001_FFFF), 64'h8080_0000_0001_0000);
    step(1'b1, 9'h033, 64'h0000_0000_FF80_0102, 64'h0000_0000_7FFF_8000, "");
    step(1'b1, 9'h035, 64'h0000_0000_FF80_0102, 64'h0000_0000_7FFF_8000, "");
    step(1'b1, 9'h036, 64'h01FF_8000_7F01_FF80, 64'h1234_8000_0001_FFFF, "");
    step(1'b1, 9'h037, 64'h01FF_8000_7F01_FF80, 64'h1234_8000_0001_FFFF, "");
    step(1'b1, 9'h038, 64'hFFFF_FFFF_FF01_80FF, 64'hFFFF_FFFF_8000_7FFF, "");
    step(1'b1, 9'h039, 64'hFFFF_FFFF_FF01_80FF, 64'hFFFF_FFFF_8000_7FFF, "");
    step(1'b1, 9'h000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "");
    step(1'b0, 9'h031, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, "");
    step(1'b0, 9'h031, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, "");
    step(1'b1, 9'h039, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_7FFF, "R6");

    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic [8:0] op;
      v  = ($urandom_range(3) != 0);
      op = ops[$urandom_range(8)];
      step(v, op, {$urandom, $urandom}, {$urandom, $urandom}, "");
    end
    step(1'b0, 9'h0, '0, '0, "");
    step(1'b0, 9'h0, '0, '0, "");
    step(1'b0, 9'h0, '0, '0, "");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule